// File: doc/BRIEF.md
# Timer Compare Output Unit

This block compares a 16-bit compare value with the count of one of two free-running timers on every clock cycle. The match condition uses a single edge. Only the first cycle on which the selected count equals the compare value counts as a match, so a timer that stops on the matching value triggers one action and no more.

On a match, the 4-bit mode decides what happens to the output latch: set it, clear it, toggle it, or leave it alone. In each of these modes the match also raises a sticky interrupt flag. A fourth active mode raises the flag and leaves the latch alone. Software sets the mode, the timer select and the compare value through a simple write port. The latch drives the output pin whenever the tri-state control input is low.

Writing certain modes loads the latch directly. This lets the edge produced by a later match be seen on the pin.

Top module: `tco_unit`

## Requirements
- R1: The compare value is checked every cycle against the full 16-bit count of timer A when `cfg_tsel` is 0, or timer B when it is 1. Equality on the timer that is not selected has no effect.
- R2: A match is acted on only on the first cycle of equality, and `pin_out` and `irq_flag` change one clock later. While the count stays equal, no further action happens.
- R3: Mode 4'b1000 sets the latch on a match. Writing this mode loads the latch with 0.
- R4: Mode 4'b1001 clears the latch on a match. Writing this mode loads the latch with 1.
- R5: Mode 4'b0010 inverts the latch on a match. Writing this mode leaves the latch as it was.
- R6: Mode 4'b1011 sets `irq_flag` on a match and leaves the latch unchanged.
- R7: Any mode other than 1000, 1001, 0010 and 1011 disables compare. A match then sets no flag and leaves the latch unchanged.
- R8: Writing mode 4'b0000 forces the latch low.
- R9: `irq_flag` is set on every match in the four active modes. It stays set until `irq_clr` is pulsed. When a match and `irq_clr` fall in the same cycle, the set takes priority.
- R10: `irq_req` is high exactly when `irq_flag` and `irq_en` are both high.
- R11: `pin_oe` is high only while `dir_in` is 0, and `pin_out` carries the latch value. When `pin_oe` is low the pin is high-impedance.
- R12: After reset the latch, the flag, the mode, the timer select and the compare value are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for mode and timer select |
| cfg_mode | input | 4 | Mode value to write |
| cfg_tsel | input | 1 | Timer select to write (0 = A, 1 = B) |
| cmp_we | input | 1 | Write strobe for the compare value |
| cmp_val | input | 16 | Compare value to write |
| tmr_a | input | 16 | Count of timer A |
| tmr_b | input | 16 | Count of timer B |
| dir_in | input | 1 | Tri-state control (1 = pin released) |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the interrupt flag |
| pin_out | output | 1 | Compare output value |
| pin_oe | output | 1 | Output enable for the pin |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- a match can never fire on two consecutive cycles;
- set, clear and toggle each move the latch as the current mode demands;
- the software-interrupt mode keeps the latch stable;
- writing the zero mode lowers the latch;
- the flag is set by an active match and is sticky.

Only the bench scenarios can show which timer actually feeds the comparator, and that a hit on the unselected timer is ignored. The same holds for the initial latch values loaded by writing a mode, for a disabled code staying silent at the ports, and for set winning over a simultaneous clear of the flag.

// File: rtl/tco_pkg.sv
package tco_pkg;
    localparam logic [3:0] MODE_OFF = 4'b0000;
    localparam logic [3:0] MODE_TOG = 4'b0010;
    localparam logic [3:0] MODE_SET = 4'b1000;
    localparam logic [3:0] MODE_CLR = 4'b1001;
    localparam logic [3:0] MODE_SWI = 4'b1011;

    function automatic logic mode_active(input logic [3:0] m);
        return (m == MODE_TOG) || (m == MODE_SET) || (m == MODE_CLR) || (m == MODE_SWI);
    endfunction
endpackage

// File: rtl/tco_regs.sv
module tco_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [3:0]       cfg_mode_i,
    input  logic             cfg_tsel_i,
    input  logic             cmp_we_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    output logic [3:0]       mode_o,
    output logic             tsel_o,
    output logic [CNT_W-1:0] cmp_o
);
    typedef struct packed {
        logic [3:0]       mode;
        logic             tsel;
        logic [CNT_W-1:0] cmp;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we_i) begin
            st_d.mode = cfg_mode_i;
            st_d.tsel = cfg_tsel_i;
        end
        if (cmp_we_i) begin
            st_d.cmp = cmp_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o = st_q.mode;
    assign tsel_o = st_q.tsel;
    assign cmp_o  = st_q.cmp;

    // R12: a fresh write lands one cycle later
    a_r12_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (mode_o == $past(cfg_mode_i)));
endmodule

// File: rtl/tco_match.sv
module tco_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tsel_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] tmr_a_i,
    input  logic [CNT_W-1:0] tmr_b_i,
    output logic             hit_o
);
    typedef struct packed {
        logic eq_prev;
    } match_t;

    match_t st_d, st_q;
    logic [CNT_W-1:0] count_sel;
    logic             eq_now;

    always_comb begin
        count_sel     = tsel_i ? tmr_b_i : tmr_a_i;
        eq_now        = (count_sel == cmp_i);
        st_d.eq_prev  = eq_now;
        hit_o         = eq_now && !st_q.eq_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a match event never repeats on the following cycle
    a_r2_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);
endmodule

// File: rtl/tco_latch.sv
module tco_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [3:0] wr_mode_i,
    input  logic [3:0] mode_i,
    input  logic       hit_i,
    output logic       latch_o
);
    import tco_pkg::*;

    typedef struct packed {
        logic level;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (wr_mode_i)
                MODE_SET: st_d.level = 1'b0;
                MODE_CLR: st_d.level = 1'b1;
                MODE_OFF: st_d.level = 1'b0;
                default:  st_d.level = st_q.level;
            endcase
        end else if (hit_i) begin
            case (mode_i)
                MODE_SET: st_d.level = 1'b1;
                MODE_CLR: st_d.level = 1'b0;
                MODE_TOG: st_d.level = !st_q.level;
                default:  st_d.level = st_q.level;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_o = st_q.level;

    a_r3_set_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !wr_i && mode_i == MODE_SET) |=> latch_o);
    a_r4_clr_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !wr_i && mode_i == MODE_CLR) |=> !latch_o);
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !wr_i && mode_i == MODE_TOG) |=> (latch_o != $past(latch_o)));
    a_r6_swi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && mode_i == MODE_SWI) |=> $stable(latch_o));
    a_r8_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wr_mode_i == MODE_OFF) |=> !latch_o);
endmodule

// File: rtl/tco_flag.sv
module tco_flag (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  logic [3:0] mode_i,
    input  logic       clr_i,
    output logic       flag_o
);
    import tco_pkg::*;

    typedef struct packed {
        logic pend;
    } flag_t;

    flag_t st_d, st_q;
    logic  fire;

    always_comb begin
        fire = hit_i && mode_active(mode_i);
        st_d = st_q;
        if (fire)       st_d.pend = 1'b1;
        else if (clr_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.pend;

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && mode_active(mode_i)) |=> flag_o);
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !mode_active(mode_i)) |=> !flag_o);
endmodule

// File: rtl/tco_unit.sv
module tco_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_mode,
    input  logic             cfg_tsel,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [CNT_W-1:0] tmr_a,
    input  logic [CNT_W-1:0] tmr_b,
    input  logic             dir_in,
    input  logic             irq_en,
    input  logic             irq_clr,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             irq_flag,
    output logic             irq_req
);
    logic [3:0]       mode_q;
    logic             tsel_q;
    logic [CNT_W-1:0] cmp_q;
    logic             hit;
    logic             latch;

    tco_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode), .cfg_tsel_i(cfg_tsel),
        .cmp_we_i(cmp_we), .cmp_val_i(cmp_val),
        .mode_o(mode_q), .tsel_o(tsel_q), .cmp_o(cmp_q)
    );

    tco_match #(.CNT_W(CNT_W)) u_match (
        .clk(clk), .rst_n(rst_n),
        .tsel_i(tsel_q), .cmp_i(cmp_q),
        .tmr_a_i(tmr_a), .tmr_b_i(tmr_b),
        .hit_o(hit)
    );

    tco_latch u_latch (
        .clk(clk), .rst_n(rst_n),
        .wr_i(cfg_we), .wr_mode_i(cfg_mode), .mode_i(mode_q),
        .hit_i(hit), .latch_o(latch)
    );

    tco_flag u_flag (
        .clk(clk), .rst_n(rst_n),
        .hit_i(hit), .mode_i(mode_q), .clr_i(irq_clr),
        .flag_o(irq_flag)
    );

    assign pin_out = latch;
    assign pin_oe  = !dir_in;
    assign irq_req = irq_flag && irq_en;
endmodule

// File: tb/tco_unit_test.sv
module tco_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_mode = 4'h0;
    logic        cfg_tsel = 1'b0;
    logic        cmp_we = 1'b0;
    logic [15:0] cmp_val = 16'h0;
    logic [15:0] tmr_a = 16'h0;
    logic [15:0] tmr_b = 16'h0;
    logic        dir_in = 1'b0;
    logic        irq_en = 1'b1;
    logic        irq_clr = 1'b0;
    logic        pin_out, pin_oe, irq_flag, irq_req;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_latch = 1'b0;

    always #5 clk = ~clk;

    tco_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_tsel(cfg_tsel), .cmp_we(cmp_we), .cmp_val(cmp_val),
        .tmr_a(tmr_a), .tmr_b(tmr_b), .dir_in(dir_in), .irq_en(irq_en),
        .irq_clr(irq_clr), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_flag(irq_flag), .irq_req(irq_req)
    );

    // vector: {tsel, hit_on_b, mode[3:0], cmp[15:0]}
    localparam logic [21:0] VEC [9] = '{
        {1'b0, 1'b0, 4'b1000, 16'h1234},  // R1 R3 timer A set
        {1'b1, 1'b1, 4'b1001, 16'hBEEF},  // R1 R4 timer B clear
        {1'b0, 1'b0, 4'b0010, 16'h0001},  // R5 toggle 0->1
        {1'b1, 1'b1, 4'b0010, 16'hFFFF},  // R5 toggle 1->0
        {1'b1, 1'b1, 4'b1000, 16'h4321},  // R3 set to 1
        {1'b1, 1'b1, 4'b1011, 16'h8000},  // R6 flag only
        {1'b0, 1'b1, 4'b1000, 16'h00A5},  // R1 unselected timer hits
        {1'b0, 1'b0, 4'b0101, 16'h7777},  // R7 disabled code
        {1'b0, 1'b0, 4'b1001, 16'h0000}   // R4 clear at zero
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic is_act(input logic [3:0] m);
        return m == 4'b1000 || m == 4'b1001 || m == 4'b0010 || m == 4'b1011;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tmr_a = 16'h5555;
        tmr_b = 16'h5555;
        tick();
        check("R12 pin", {15'b0, pin_out}, 16'h0);
        check("R12 flag", {15'b0, irq_flag}, 16'h0);
        rst_n = 1'b1;
        tick();
        tick();
        check("R12 flag after release", {15'b0, irq_flag}, 16'h0);

        for (int i = 0; i < 9; i++) begin
            logic       v_tsel, v_onb, hit_sel, exp_flag;
            logic [3:0] v_mode;
            logic [15:0] v_cmp;
            {v_tsel, v_onb, v_mode, v_cmp} = VEC[i];
            cfg_we = 1'b1; cfg_mode = v_mode; cfg_tsel = v_tsel;
            cmp_we = 1'b1; cmp_val = v_cmp; irq_clr = 1'b1;
            tmr_a = v_cmp ^ 16'h5555; tmr_b = v_cmp ^ 16'h5555;
            tick();
            cfg_we = 1'b0; cmp_we = 1'b0; irq_clr = 1'b0;
            if (v_mode == 4'b1000 || v_mode == 4'b0000) exp_latch = 1'b0;
            else if (v_mode == 4'b1001) exp_latch = 1'b1;
            tick();
            check("R3 R4 R5 write init", {15'b0, pin_out}, {15'b0, exp_latch});
            if (v_onb) tmr_b = v_cmp; else tmr_a = v_cmp;
            hit_sel = (v_onb == v_tsel);
            exp_flag = hit_sel && is_act(v_mode);
            if (hit_sel) begin
                case (v_mode)
                    4'b1000: exp_latch = 1'b1;
                    4'b1001: exp_latch = 1'b0;
                    4'b0010: exp_latch = !exp_latch;
                    default: exp_latch = exp_latch;
                endcase
            end
            tick();
            check("R1 R3 R4 R5 R6 R7 pin after match", {15'b0, pin_out}, {15'b0, exp_latch});
            check("R9 R6 R7 flag", {15'b0, irq_flag}, {15'b0, exp_flag});
            check("R10 req", {15'b0, irq_req}, {15'b0, exp_flag});
            tick();
            check("R2 held match no repeat", {15'b0, pin_out}, {15'b0, exp_latch});
        end

        // R9 set wins over clear in the same cycle
        cfg_we = 1'b1; cfg_mode = 4'b1000; cfg_tsel = 1'b0;
        cmp_we = 1'b1; cmp_val = 16'h0F0F; irq_clr = 1'b1;
        tmr_a = 16'h1111; tmr_b = 16'h1111;
        tick();
        cfg_we = 1'b0; cmp_we = 1'b0; irq_clr = 1'b0;
        tick();
        check("R9 cleared", {15'b0, irq_flag}, 16'h0);
        tmr_a = 16'h0F0F; irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        check("R9 set beats clear", {15'b0, irq_flag}, 16'h1);
        tick(); tick();
        check("R9 sticky", {15'b0, irq_flag}, 16'h1);
        irq_en = 1'b0;
        tick();
        check("R10 enable low", {15'b0, irq_req}, 16'h0);
        irq_en = 1'b1;
        tick();
        check("R10 enable high", {15'b0, irq_req}, 16'h1);
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        check("R9 clear", {15'b0, irq_flag}, 16'h0);

        // R11 tri-state
        check("R11 drive", {15'b0, pin_oe}, 16'h1);
        check("R11 value", {15'b0, pin_out}, 16'h1);
        dir_in = 1'b1;
        tick();
        check("R11 released", {15'b0, pin_oe}, 16'h0);
        dir_in = 1'b0;

        // R8 zero mode forces low
        cfg_we = 1'b1; cfg_mode = 4'b0000;
        tick();
        cfg_we = 1'b0;
        check("R8 zero mode low", {15'b0, pin_out}, 16'h0);
        tmr_a = 16'h2222; tick();
        tmr_a = 16'h0F0F; tick(); tick();
        check("R7 off no flag", {15'b0, irq_flag}, 16'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule